// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital timing and control engine of a 12-bit successive-approximation ADC. A 16-bit control register holds the input channel, the coding mode, an acquisition-length select and an ADC clock divide select. A start pulse launches one conversion. The block derives an ADC clock enable from the system clock and counts ADC clocks through the acquisition phase and then a fixed run of bit-trial and write clocks. On the final ADC clock it samples the raw 12-bit code presented on an input port and writes it, aligned and coded by mode, into a 32-bit data word.

Busy is high for the whole conversion. When the result is written, a done flag and an interrupt line rise. Both stay high until software reads the data word or starts another conversion. The timing settings are captured at the start, so writes to the control register during a conversion affect only the next one. Channel 15 is the temperature-sensor channel. It always runs with its own fixed timing, and the next conversion on any other channel goes back to the programmed values.

Top module: `adc_seq_top`

## Requirements
- R1: The control register resets to 0x0600, and every write on `ctl_we` stores all 16 bits, which read back unchanged on `ctl_rdata`. Field layout: [1:0] mode, [7:4] channel, [10:9] acquisition select, [15:13] divide select. Bits 2, 3, 8, 11 and 12 are stored but have no effect.
- R2: With the reset control value, a conversion takes 8 acquisition ADC clocks plus 19 more, with one ADC clock per 2 system clocks. Busy is therefore high for exactly 54 system clocks.
- R3: For any channel other than 15, acquisition lasts 2^asel ADC clocks and the ADC clock period is 2^(dsel+1) system clocks. Busy lasts (2^asel + 19) * 2^(dsel+1) system clocks, and `adc_tick` pulses only while busy.
- R4: On channel 15, the block ignores the select fields and uses 16 acquisition clocks with a divide of 32, so busy lasts 1120 system clocks.
- R5: A conversion on another channel that follows a channel-15 conversion uses the programmed acquisition and divide values again.
- R6: In single-ended mode (00), pseudo-differential mode (01) and the spare code 11, the data word holds the code in bits 27:16 with every other bit zero.
- R7: In fully differential mode (10), the data word holds the code in bits 27:16, bits 31:28 copy bit 27, and bits 15:0 are zero.
- R8: Busy rises on the clock edge that accepts a start and falls on the edge that writes the result. Done and `irq` rise on that same edge.
- R9: Done and `irq` clear on the edge after a `dat_rd` pulse, and they also clear on the edge that accepts a new start.
- R10: A start pulse while busy is high is ignored, and the running conversion keeps its length.
- R11: The result is the value on `raw_code` at the final ADC clock enable. Changes on `raw_code` before or after that enable do not alter the data word.
- R12: The timing and mode are captured when the start is accepted, so control writes during a conversion do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register contents |
| start | input | 1 | Conversion start request |
| dat_rd | input | 1 | Data word read strobe, clears done |
| raw_code | input | 12 | Raw conversion code from the analog core |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result written and not yet read |
| irq | output | 1 | Conversion-complete interrupt |
| adc_tick | output | 1 | One-cycle ADC clock enable |
| adc_data | output | 32 | Aligned, mode-coded result word |

## Verification
The bench builds the block with its default parameters: a 12-bit code placed at bit 16 of a 32-bit word, 19 extra clocks, channel 15 as the temperature channel with 16 acquisition clocks and a divide of 32, a 2-bit acquisition select and a 3-bit divide select. With these values every acquisition length and the divide values 2 to 16 can be timed to the exact cycle against the product formula. The reset value and the fixed temperature timing of 1120 cycles are also covered, so a conversion sequence goes from user timing to temperature timing and back within a short run. The two-sided sign extension gets directed codes with the top bit set and clear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // control register geometry; field positions are decoded by software
    localparam int CTL_W     = 16;
    localparam logic [CTL_W-1:0] CTL_RESET = 16'h0600;
    localparam int MODE_LSB  = 0;
    localparam int MODE_W    = 2;
    localparam int CHAN_LSB  = 4;
    localparam int CHAN_W    = 4;
    localparam int ASEL_LSB  = 9;
    localparam int ASEL_W    = 2;
    localparam int DSEL_LSB  = 13;
    localparam int DSEL_W    = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_SINGLE = 2'b00,
        MODE_PSEUDO = 2'b01,
        MODE_DIFF   = 2'b10,
        MODE_SPARE  = 2'b11
    } adc_mode_e;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == div_val - DIV_W'(1));
        tick = run && wrap;
        if (!run || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic              tick,
    input  logic [TICK_W-1:0] total,
    output logic              launch,
    output logic              finish,
    output logic              busy,
    output logic              done,
    output logic              irq
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              irq;
        logic [TICK_W-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        launch = start && !st_q.busy;
        finish = st_q.busy && tick && (st_q.cnt == total - TICK_W'(1));
        if (launch) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end else if (st_q.busy) begin
            if (finish) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
                st_d.irq  = 1'b1;
            end else if (tick) begin
                st_d.cnt = st_q.cnt + TICK_W'(1);
            end
        end else if (rd) begin
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign irq  = st_q.irq;

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int RES_W   = 12,
    parameter int DATA_W  = 32,
    parameter int RES_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              diff,
    input  logic [RES_W-1:0]  code,
    output logic [DATA_W-1:0] data
);

    localparam int SIGN_LSB = RES_LSB + RES_W;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } fmt_state_t;

    fmt_state_t        st_d, st_q;
    logic [DATA_W-1:0] coded;

    always_comb begin
        coded = '0;
        coded[RES_LSB +: RES_W] = code;
        for (int i = SIGN_LSB; i < DATA_W; i++) begin
            coded[i] = diff & code[RES_W-1];
        end
        st_d = st_q;
        if (load) begin
            st_d.word = coded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.word;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int DATA_W     = 32,
    parameter int RES_LSB    = 16,
    parameter int EXTRA_CLKS = 19,
    parameter int TEMP_CH    = 15,
    parameter int TEMP_ACQ   = 16,
    parameter int TEMP_DIV   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              start,
    input  logic              dat_rd,
    input  logic [RES_W-1:0]  raw_code,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              adc_tick,
    output logic [DATA_W-1:0] adc_data
);

    localparam int MAX_ACQ = 1 << ((1 << ASEL_W) - 1);
    localparam int ACQ_TOP = (MAX_ACQ > TEMP_ACQ) ? MAX_ACQ : TEMP_ACQ;
    localparam int TICK_W  = $clog2(ACQ_TOP + EXTRA_CLKS + 1);
    localparam int MAX_DIV = 2 << ((1 << DSEL_W) - 1);
    localparam int DIV_TOP = (MAX_DIV > TEMP_DIV) ? MAX_DIV : TEMP_DIV;
    localparam int DIV_W   = $clog2(DIV_TOP + 1);

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [TICK_W-1:0] total;
        logic [DIV_W-1:0]  div;
        logic              diff;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              launch;
    logic              finish;
    logic              tick;
    logic [CHAN_W-1:0] chan;
    logic [ASEL_W-1:0] asel;
    logic [DSEL_W-1:0] dsel;
    adc_mode_e         mode;
    logic [TICK_W-1:0] acq_len;
    logic [DIV_W-1:0]  div_len;

    always_comb begin
        chan = st_q.ctl[CHAN_LSB +: CHAN_W];
        asel = st_q.ctl[ASEL_LSB +: ASEL_W];
        dsel = st_q.ctl[DSEL_LSB +: DSEL_W];
        mode = adc_mode_e'(st_q.ctl[MODE_LSB +: MODE_W]);
        if (chan == CHAN_W'(TEMP_CH)) begin
            acq_len = TICK_W'(TEMP_ACQ);
            div_len = DIV_W'(TEMP_DIV);
        end else begin
            acq_len = TICK_W'(1) << asel;
            div_len = DIV_W'(2) << dsel;
        end
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_wdata;
        end
        if (launch) begin
            st_d.total = acq_len + TICK_W'(EXTRA_CLKS);
            st_d.div   = div_len;
            st_d.diff  = (mode == MODE_DIFF);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl   <= CTL_RESET;
            st_q.total <= TICK_W'(EXTRA_CLKS + 8);
            st_q.div   <= DIV_W'(2);
            st_q.diff  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    adc_seq_clkdiv #(
        .DIV_W (DIV_W)
    ) u_clkdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .div_val (st_q.div),
        .tick    (tick)
    );

    adc_seq_ctrl #(
        .TICK_W (TICK_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rd     (dat_rd),
        .tick   (tick),
        .total  (st_q.total),
        .launch (launch),
        .finish (finish),
        .busy   (busy),
        .done   (done),
        .irq    (irq)
    );

    adc_seq_fmt #(
        .RES_W   (RES_W),
        .DATA_W  (DATA_W),
        .RES_LSB (RES_LSB)
    ) u_fmt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (finish),
        .diff  (st_q.diff),
        .code  (raw_code),
        .data  (adc_data)
    );

    assign ctl_rdata = st_q.ctl;
    assign adc_tick  = tick;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CTL_W   = 16,
    parameter int RES_W   = 12,
    parameter int DATA_W  = 32,
    parameter int RES_LSB = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              start,
    input logic              dat_rd,
    input logic              busy,
    input logic              done,
    input logic              irq,
    input logic              adc_tick,
    input logic [DATA_W-1:0] adc_data
);

    localparam int SIGN_LSB = RES_LSB + RES_W;
    localparam int SIGN_W   = DATA_W - SIGN_LSB;

    logic [SIGN_W-1:0] sign_bits;
    assign sign_bits = adc_data[DATA_W-1:SIGN_LSB];

    assert_ctl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rdata));

    assert_tick_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_tick |-> busy);

    assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_data[RES_LSB-1:0] == '0);

    assert_sign_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_bits == '0) || (sign_bits == {SIGN_W{adc_data[SIGN_LSB-1]}}));

    assert_done_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && irq));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!done && !irq));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && done && !busy && !start) |=> (!done && !irq));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !adc_tick) |=> busy);

    assert_end_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(adc_tick));

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && adc_tick) |=> $stable(adc_data));

endmodule

bind adc_seq_top adc_seq_chk #(
    .CTL_W   (adc_seq_pkg::CTL_W),
    .RES_W   (RES_W),
    .DATA_W  (DATA_W),
    .RES_LSB (RES_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_rdata (ctl_rdata),
    .start     (start),
    .dat_rd    (dat_rd),
    .busy      (busy),
    .done      (done),
    .irq       (irq),
    .adc_tick  (adc_tick),
    .adc_data  (adc_data)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [15:0] ctl_wdata;
    logic [15:0] ctl_rdata;
    logic        start;
    logic        dat_rd;
    logic [11:0] raw_code;
    logic        busy;
    logic        done;
    logic        irq;
    logic        adc_tick;
    logic [31:0] adc_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_seq_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .start     (start),
        .dat_rd    (dat_rd),
        .raw_code  (raw_code),
        .busy      (busy),
        .done      (done),
        .irq       (irq),
        .adc_tick  (adc_tick),
        .adc_data  (adc_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, act cycle %0d exp completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fmt_word(input logic [15:0] ctl, input logic [11:0] code);
        if (ctl[1:0] == 2'b10) return {{4{code[11]}}, code, 16'h0000};
        return {4'h0, code, 16'h0000};
    endfunction

    function automatic int conv_len(input logic [15:0] ctl);
        if (ctl[7:4] == 4'd15) return (16 + 19) * 32;
        return ((1 << ctl[10:9]) + 19) * (2 << ctl[15:13]);
    endfunction

    function automatic logic [15:0] rand_ctl(input bit temp);
        logic [15:0] v;
        v = 16'($urandom);
        v[15:13] = 3'($urandom_range(0, 3));
        if (temp) v[7:4] = 4'd15;
        else if (v[7:4] == 4'd15) v[7:4] = 4'd3;
        return v;
    endfunction

    // caller stands just after a negedge; returns just after a negedge
    task automatic write_ctl(input logic [15:0] v);
        ctl_we    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic run_conv(input logic [15:0] v, input logic [11:0] code,
                            input bit mid_write, input bit mid_start, input string tag);
        int          len;
        int          hi;
        logic [15:0] v2;
        logic [31:0] exp_word;
        len      = conv_len(v);
        hi       = 0;
        v2       = rand_ctl($urandom_range(0, 1) == 1);
        exp_word = fmt_word(v, code);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && irq == 1'b0, "R9 start clears done", {30'd0, done, irq}, 32'd0);
        for (int n = 1; n <= len; n++) begin
            hi += int'(busy);
            raw_code = (n == len) ? code : 12'($urandom);
            if (mid_write && n == 2) begin
                ctl_we    = 1'b1;
                ctl_wdata = v2;
            end
            if (mid_write && n == 3) ctl_we = 1'b0;
            if (mid_start && n == 4) start = 1'b1;
            if (mid_start && n == 5) start = 1'b0;
            @(negedge clk);
        end
        check(hi == len && busy == 1'b0, tag, 32'(hi), 32'(len));
        check(done && irq, "R8 done and irq at write", {30'd0, done, irq}, 32'd3);
        check(adc_data == exp_word, (v[1:0] == 2'b10) ? "R7 diff word" : "R6 binary word",
              adc_data, exp_word);
        if (mid_write) check(ctl_rdata == v2, "R1 readback after write", 32'(ctl_rdata), 32'(v2));
        raw_code = ~code;
        @(negedge clk);
        check(adc_data == exp_word, "R11 late code change ignored", adc_data, exp_word);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] user_v;
        rst_n     = 1'b0;
        ctl_we    = 1'b0;
        ctl_wdata = '0;
        start     = 1'b0;
        dat_rd    = 1'b0;
        raw_code  = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(ctl_rdata == 16'h0600, "R1 reset ctl", 32'(ctl_rdata), 32'h0600);
        check(!busy && !done && !irq && adc_data == 0, "R8 reset outputs",
              adc_data, 32'd0);

        // default timing, straight binary
        run_conv(16'h0600, 12'hA5C, 1'b0, 1'b0, "R2 default busy length");

        // read clears done and irq, data kept
        dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
        check(!done && !irq, "R9 read clears done", {30'd0, done, irq}, 32'd0);
        check(adc_data == 32'h0A5C0000, "R9 read keeps data", adc_data, 32'h0A5C0000);

        // differential, negative and positive codes
        write_ctl(16'h0202);
        run_conv(16'h0202, 12'h801, 1'b0, 1'b0, "R3 diff busy length");
        run_conv(16'h0202, 12'h7FF, 1'b0, 1'b0, "R3 diff busy length");
        write_ctl(16'h0203);
        run_conv(16'h0203, 12'hFFF, 1'b0, 1'b0, "R6 spare mode length");

        // start while busy ignored, ctl write during conversion ignored
        user_v = 16'h2201;
        write_ctl(user_v);
        run_conv(user_v, 12'h123, 1'b1, 1'b1, "R10 R12 busy length");

        // temperature channel then back to user timing
        user_v = 16'h4432;
        write_ctl({user_v[15:8], 4'd15, user_v[3:0]});
        run_conv({user_v[15:8], 4'd15, user_v[3:0]}, 12'h9AB, 1'b0, 1'b0, "R4 temp busy length");
        write_ctl(user_v);
        run_conv(user_v, 12'h456, 1'b0, 1'b0, "R5 user timing after temp");

        // random conversions
        for (int k = 0; k < 24; k++) begin
            v = rand_ctl(k % 8 == 7);
            write_ctl(v);
            run_conv(v, 12'($urandom), k % 3 == 0, k % 4 == 1,
                     (v[7:4] == 4'd15) ? "R4 random temp length" : "R3 random busy length");
            if (k % 2 == 0) begin
                dat_rd = 1'b1;
                @(negedge clk);
                dat_rd = 1'b0;
                check(!done && !irq, "R9 random read clears", {30'd0, done, irq}, 32'd0);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule